// File: doc/BRIEF.md
# Instruction Single-Step Interrupt Generator

This block gives a debug monitor hardware single-stepping on a processor that marks each instruction fetch with an acquisition strobe and decodes a dedicated external instruction. When the monitor executes that arming instruction, the block puts a token into a short chain of flip-flops. Each later instruction-fetch edge moves the token one stage along. When the token reaches the last stage, the block drives the active-low non-maskable load interrupt request. The processor then vectors back into the monitor after exactly one user instruction has run.

The request stays low until the next fetch edge, which is the processor taking the interrupt vector. That edge moves the token out of the chain, and the chain is then empty. The count is made in fetch edges rather than clock cycles. With three stages, one user instruction still runs per step on cores that prefetch their next instruction. A step-enable input lets software execute the arming instruction without starting a step. A synchronous reset empties the chain.

Top module: `step_irq_gen`

## Requirements
- R1: While `srst` is high at a clock edge, the chain is emptied, and `load_req_n` is high after that edge.
- R2: `arm_strobe` high with `step_en` high at a clock edge starts a step. `load_req_n` is high after that edge.
- R3: After a step is started, `load_req_n` goes low on the edge that samples the (STAGES-1)th rising edge of `fetch_strobe`. With the default STAGES=3, this is the second rising edge.
- R4: Once low, `load_req_n` stays low until the next rising edge of `fetch_strobe`. It then returns high and stays high for any further fetch edges until a new step is armed.
- R5: Only a low-to-high transition of `fetch_strobe` advances the chain (EDGE_DETECT=1). A strobe held high for several cycles counts once, and cycles with the strobe low have no effect.
- R6: An arming strobe while a step is in progress, including while `load_req_n` is low, restarts the count from the first stage. `load_req_n` is high after it.
- R7: With `step_en` low, `arm_strobe` is ignored: `load_req_n` stays high through the fetch edges that follow.
- R8: When arming and a fetch rising edge occur in the same cycle, arming wins. That fetch edge is not counted.
- R9: Fetch edges with no step armed leave `load_req_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Allows the arming strobe to start a step |
| arm_strobe | input | 1 | Decode strobe of the step-arming external instruction |
| fetch_strobe | input | 1 | Instruction-acquisition strobe of the processor |
| load_req_n | output | 1 | Non-maskable load interrupt request, active low |

## Verification
The bench builds the block with its defaults: three stages and internal edge detection on the fetch strobe. The two-edge step window and the prefetch-tolerant timing are therefore exercised as specified. Because of the edge detection, the bench can hold the fetch strobe high for several cycles and show that it counts once. A separate pulse-input variant, or a longer chain, would have to be elaborated on its own.

// File: rtl/step_irq_pkg.sv
package step_irq_pkg;

   // Action applied to the token chain in one clock cycle
   typedef enum logic [1:0] {
      CH_HOLD  = 2'd0,
      CH_ARM   = 2'd1,
      CH_SHIFT = 2'd2
   } chain_act_e;

   // Smallest chain that still gives one instruction per step
   localparam int unsigned MIN_STAGES = 2;

endpackage

// File: rtl/step_irq_fetch_edge.sv
module step_irq_fetch_edge #(
   parameter bit EDGE_DETECT = 1'b1
) (
   input  logic clk,
   input  logic srst,
   input  logic strobe_in,
   output logic fetch_pulse
);

   generate
      if (EDGE_DETECT) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk) begin
            if (srst) prev_q <= 1'b0;
            else      prev_q <= strobe_in;
         end
         assign fetch_pulse = strobe_in & ~prev_q;
      end else begin : g_pulse
         // Strobe is already a one-cycle pulse per fetch
         assign fetch_pulse = strobe_in;
      end
   endgenerate

endmodule

// File: rtl/step_irq_chain.sv
module step_irq_chain
   import step_irq_pkg::*;
#(
   parameter int unsigned STAGES = 3
) (
   input  logic              clk,
   input  logic              srst,
   input  chain_act_e        act,
   output logic [STAGES-1:0] chain_q
);

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (srst) begin
               chain_q[i] <= 1'b0;
            end else begin
               unique case (act)
                  CH_ARM:   chain_q[i] <= (i == 0);
                  CH_SHIFT: begin
                     if (i == 0) chain_q[i] <= 1'b0;
                     else        chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
                  end
                  default:  chain_q[i] <= chain_q[i];
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/step_irq_gen.sv
module step_irq_gen
   import step_irq_pkg::*;
#(
   parameter int unsigned STAGES      = 3,
   parameter bit          EDGE_DETECT = 1'b1
) (
   input  logic clk,
   input  logic srst,
   input  logic step_en,
   input  logic arm_strobe,
   input  logic fetch_strobe,
   output logic load_req_n
);

   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < MIN_STAGES) begin : g_bad_stages
         $error("step_irq_gen: STAGES must be at least %0d", MIN_STAGES);
      end
   endgenerate

   logic              fetch_pulse;
   logic              arm_ok;
   logic [STAGES-1:0] chain_q;
   chain_act_e        act;

   step_irq_fetch_edge #(.EDGE_DETECT(EDGE_DETECT)) u_edge (
      .clk         (clk),
      .srst        (srst),
      .strobe_in   (fetch_strobe),
      .fetch_pulse (fetch_pulse)
   );

   assign arm_ok = arm_strobe & step_en;

   always_comb begin
      if (arm_ok)                       act = CH_ARM;
      else if (fetch_pulse && |chain_q) act = CH_SHIFT;
      else                              act = CH_HOLD;
   end

   step_irq_chain #(.STAGES(STAGES)) u_chain (
      .clk     (clk),
      .srst    (srst),
      .act     (act),
      .chain_q (chain_q)
   );

   assign load_req_n = ~chain_q[LAST];

endmodule

// File: rtl/step_irq_gen_chk.sv
module step_irq_gen_chk #(
   parameter int unsigned STAGES = 3
) (
   input logic              clk,
   input logic              srst,
   input logic              step_en,
   input logic              arm_strobe,
   input logic              fetch_pulse,
   input logic [STAGES-1:0] chain_q,
   input logic              load_req_n
);

   logic arm_ok_c;
   assign arm_ok_c = arm_strobe & step_en;

   // R1
   reset_clears_chk: assert property (@(posedge clk) srst |=> (load_req_n && chain_q == '0));

   // R2
   arm_starts_chk: assert property (@(posedge clk) disable iff (srst)
      arm_ok_c |=> (load_req_n && chain_q == {{(STAGES-1){1'b0}}, 1'b1}));

   // R3
   load_raise_chk: assert property (@(posedge clk) disable iff (srst)
      (fetch_pulse && chain_q[STAGES-2] && !arm_ok_c) |=> !load_req_n);

   // R4
   load_release_chk: assert property (@(posedge clk) disable iff (srst)
      (!load_req_n && fetch_pulse && !arm_ok_c) |=> (load_req_n && chain_q == '0));

   // R5
   no_edge_hold_chk: assert property (@(posedge clk) disable iff (srst)
      (!fetch_pulse && !arm_ok_c) |=> $stable(chain_q));

   // R7
   disabled_arm_chk: assert property (@(posedge clk) disable iff (srst)
      (arm_strobe && !step_en && chain_q == '0) |=> chain_q == '0);

   // R6
   single_token_chk: assert property (@(posedge clk) disable iff (srst) $onehot0(chain_q));

endmodule

bind step_irq_gen step_irq_gen_chk #(.STAGES(STAGES)) u_chk (
   .clk         (clk),
   .srst        (srst),
   .step_en     (step_en),
   .arm_strobe  (arm_strobe),
   .fetch_pulse (fetch_pulse),
   .chain_q     (chain_q),
   .load_req_n  (load_req_n)
);

// File: tb/tb_step_irq_gen.sv
module tb_step_irq_gen;

   localparam int CLK_PERIOD = 10;
   localparam int STAGES     = 3;
   localparam int WATCHDOG   = 5000;

   logic clk = 1'b0;
   logic srst = 1'b1;
   logic step_en = 1'b0;
   logic arm_strobe = 1'b0;
   logic fetch_strobe = 1'b0;
   logic load_req_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   step_irq_gen #(.STAGES(STAGES), .EDGE_DETECT(1'b1)) dut (
      .clk          (clk),
      .srst         (srst),
      .step_en      (step_en),
      .arm_strobe   (arm_strobe),
      .fetch_strobe (fetch_strobe),
      .load_req_n   (load_req_n)
   );

   typedef struct {
      bit    exp;
      string tag;
   } item_t;

   item_t exp_q[$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;

   // Reference model: fetch edges counted since arming, -1 when idle
   int m_cnt  = -1;
   bit m_prev = 1'b0;

   task automatic drive(bit r, bit a, bit e, bit f, string tag);
      item_t it;
      bit    rise;
      @(negedge clk);
      srst = r; arm_strobe = a; step_en = e; fetch_strobe = f;
      if (r) begin
         m_cnt = -1; m_prev = 1'b0;
      end else begin
         rise   = f && !m_prev;
         m_prev = f;
         if (a && e) m_cnt = 0;
         else if (rise && m_cnt >= 0) begin
            m_cnt++;
            if (m_cnt >= STAGES) m_cnt = -1;
         end
      end
      it.exp = !(m_cnt == STAGES - 1);
      it.tag = tag;
      exp_q.push_back(it);
   endtask

   // Monitor: compares after each edge, away from it
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (load_req_n !== it.exp) begin
               fails++;
               $display("FAIL %s: load_req_n=%b expected %b", it.tag, load_req_n, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      drive(1, 0, 0, 0, "R1");
      drive(1, 0, 0, 0, "R1");
      // R9 fetches with nothing armed
      drive(0, 0, 1, 1, "R9");
      drive(0, 0, 1, 0, "R9");
      drive(0, 0, 1, 1, "R9");
      drive(0, 0, 1, 0, "R9");
      // R2 arm, R3 two fetch edges, R4 hold and release
      drive(0, 1, 1, 0, "R2");
      drive(0, 0, 1, 1, "R3");
      drive(0, 0, 1, 0, "R3");
      drive(0, 0, 1, 1, "R3");
      drive(0, 0, 1, 1, "R4");
      drive(0, 0, 1, 0, "R4");
      drive(0, 0, 1, 0, "R4");
      drive(0, 0, 1, 1, "R4");
      drive(0, 0, 1, 0, "R4");
      drive(0, 0, 1, 1, "R4");
      drive(0, 0, 1, 0, "R4");
      // R5 held-high strobe counts once
      drive(0, 1, 1, 0, "R5");
      drive(0, 0, 1, 1, "R5");
      for (int i = 0; i < 4; i++) drive(0, 0, 1, 1, "R5");
      drive(0, 0, 1, 0, "R5");
      drive(0, 0, 1, 0, "R5");
      drive(0, 0, 1, 1, "R5");
      drive(0, 0, 1, 0, "R5");
      // R6 re-arm while request is low, then full count again
      drive(0, 1, 1, 0, "R6");
      drive(0, 0, 1, 1, "R6");
      drive(0, 1, 1, 0, "R6");
      drive(0, 0, 1, 1, "R6");
      drive(0, 0, 1, 0, "R6");
      drive(0, 0, 1, 1, "R6");
      drive(0, 0, 1, 0, "R6");
      drive(0, 0, 1, 1, "R6");
      drive(0, 0, 1, 0, "R6");
      // R7 arming with step disabled is ignored
      drive(0, 1, 0, 0, "R7");
      for (int i = 0; i < 3; i++) begin
         drive(0, 0, 0, 1, "R7");
         drive(0, 0, 0, 0, "R7");
      end
      // R8 arm and fetch edge in the same cycle
      drive(0, 1, 1, 1, "R8");
      drive(0, 0, 1, 0, "R8");
      drive(0, 0, 1, 1, "R8");
      drive(0, 0, 1, 0, "R8");
      drive(0, 0, 1, 1, "R8");
      drive(0, 0, 1, 0, "R8");
      // R1 reset in the middle of a request
      drive(0, 1, 1, 0, "R1");
      drive(0, 0, 1, 1, "R1");
      drive(0, 0, 1, 0, "R1");
      drive(0, 0, 1, 1, "R1");
      drive(1, 0, 1, 0, "R1");
      drive(0, 0, 1, 1, "R1");
      drive(0, 0, 1, 0, "R1");
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule